// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block is the architectural register storage of a small load/store processor core. It holds 32 words of 32 bits. Two read ports, each with its own 5-bit index, return register contents combinationally, so the decode stage can fetch both source operands in the same cycle it presents their indices. A single write port with an index, a data word and an enable commits the result of the writeback stage.

The write port is clocked on the falling edge of the clock. A result written in one clock period is therefore already visible to the read ports during the low phase of that same period, before the next rising edge, and the reading logic needs no bypass path for this case. Entry 0 is a constant: it reads as zero on both ports and no write changes it. An active-high synchronous reset, sampled on the same falling edge as writes, clears every entry.

Top module: `regbank_2r1w`

## Requirements
- R1: After a reset, every index from 0 to 31 reads 0x00000000 on both read ports.
- R2: A read port whose index is 0 returns 0x00000000, whatever has been written.
- R3: A write with enable high and index 0 leaves entry 0 reading 0x00000000 on both ports.
- R4: A write attempt with enable low changes no entry; the addressed index still reads its previous value.
- R5: A write with enable high and a nonzero index stores the data word on the falling clock edge; the new value is readable before the following rising edge.
- R6: Between the rising edge and the falling edge in which a write is presented, the addressed entry still reads its old value.
- R7: Read outputs follow a change of the read index without any clock edge.
- R8: The two read ports are independent: different indices return their own entries at the same time.
- R9: When both read indices are equal, both ports return the same value.
- R10: Reset sampled high on a falling edge overrides a simultaneous write; the addressed entry reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Word to write |
| rd_idx_a | input | 5 | Index for read port A |
| rd_data_a | output | 32 | Contents of the entry selected on port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_b | output | 32 | Contents of the entry selected on port B |

## Verification
A corrupted entry shows up at the ports only when one of the read indices selects it, and then at once, since reads are combinational; the bench therefore reads each written entry back in the same clock period as the write and sweeps all indices after reset. A write landing in the wrong row or on the wrong edge is visible in the low half of that period, either as a stale value at the target or a changed value at a neighbour read later. A broken zero entry appears as nonzero data whenever index 0 is selected after a write to it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned RB_DATA_W = 32;
  localparam int unsigned RB_ADDR_W = 5;
endpackage

// File: rtl/regbank_wrdec.sv
module regbank_wrdec #(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  output logic [DEPTH-1:0]  row_we
);
  // Row 0 is constant, so it never receives a strobe.
  assign row_we[0] = 1'b0;

  for (genvar r = 1; r < DEPTH; r++) begin : g_row
    assign row_we[r] = wr_en && (wr_idx == ADDR_W'(r));
  end

  // R4
  wen_gate_chk: assert property (@(negedge clk) disable iff (rst)
    !wr_en |-> (row_we == '0));

  // R3
  zero_row_chk: assert property (@(negedge clk) disable iff (rst)
    (wr_en && wr_idx == '0) |-> !(|row_we));
endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DEPTH-1:0]        row_we,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DEPTH*DATA_W-1:0] rows_flat
);
  assign rows_flat[DATA_W-1:0] = '0;

  for (genvar r = 1; r < DEPTH; r++) begin : g_row
    logic [DATA_W-1:0] row_q;

    always_ff @(negedge clk) begin
      if (rst)
        row_q <= '0;
      else if (row_we[r])
        row_q <= wr_data;
    end

    assign rows_flat[r*DATA_W +: DATA_W] = row_q;

    // R5
    wr_commit_chk: assert property (@(negedge clk) disable iff (rst)
      row_we[r] |=> (row_q == $past(wr_data)));
  end

  // R4
  idle_hold_chk: assert property (@(negedge clk) disable iff (rst)
    !(|row_we) |=> $stable(rows_flat));
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH*DATA_W-1:0] rows_flat,
  input  logic [ADDR_W-1:0]       rd_idx,
  output logic [DATA_W-1:0]       rd_data
);
  always_comb begin
    if (rd_idx == '0)
      rd_data = '0;
    else
      rd_data = rows_flat[rd_idx*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/regbank_2r1w.sv
module regbank_2r1w
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = RB_DATA_W,
  parameter int unsigned ADDR_W = RB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned NPORT = 2;

  logic [DEPTH-1:0]        row_we;
  logic [DEPTH*DATA_W-1:0] rows_flat;
  logic [ADDR_W-1:0]       port_idx  [NPORT];
  logic [DATA_W-1:0]       port_data [NPORT];

  regbank_wrdec #(.ADDR_W(ADDR_W)) u_wrdec (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .row_we (row_we)
  );

  regbank_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .row_we    (row_we),
    .wr_data   (wr_data),
    .rows_flat (rows_flat)
  );

  assign port_idx[0] = rd_idx_a;
  assign port_idx[1] = rd_idx_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    regbank_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .rows_flat (rows_flat),
      .rd_idx    (port_idx[p]),
      .rd_data   (port_data[p])
    );
  end

  assign rd_data_a = port_data[0];
  assign rd_data_b = port_data[1];

  // R2
  zero_rda_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_a == '0) |-> (rd_data_a == '0));

  // R2
  zero_rdb_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_b == '0) |-> (rd_data_b == '0));

  // R9
  same_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));
endmodule

// File: tb/test_regbank_2r1w.sv
module test_regbank_2r1w;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx_a = '0;
  logic [31:0] rd_data_a;
  logic [4:0]  rd_idx_b = '0;
  logic [31:0] rd_data_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] mdl [32];

  // {enable, index, data}
  localparam int NVEC = 8;
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b1, 5'd1,  32'hDEADBEEF},
    {1'b1, 5'd31, 32'h12345678},
    {1'b1, 5'd0,  32'hFFFFFFFF},
    {1'b0, 5'd7,  32'hA5A5A5A5},
    {1'b1, 5'd7,  32'h0F0F0F0F},
    {1'b1, 5'd7,  32'hCAFEF00D},
    {1'b1, 5'd16, 32'h80000001},
    {1'b0, 5'd1,  32'h00000000}
  };

  always #5 clk = ~clk;

  regbank_2r1w i_regbank_2r1w (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst = 1'b0;

    // R1: every entry cleared after reset, both ports
    for (int i = 0; i < 32; i++) begin
      rd_idx_a = 5'(i); rd_idx_b = 5'(31 - i); #1;
      chk("R1 port A", rd_data_a, 32'h0);
      chk("R1 port B", rd_data_b, 32'h0);
    end

    // Table walk: R3 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      logic        en;
      logic [4:0]  ix;
      logic [31:0] dt;
      {en, ix, dt} = VEC[v];
      @(posedge clk); #1;
      wr_en = en; wr_idx = ix; wr_data = dt;
      rd_idx_a = ix; rd_idx_b = ix; #1;
      chk("R6 old value before falling edge", rd_data_a, mdl[ix]);
      @(negedge clk); #1;
      if (en && ix != 0) mdl[ix] = dt;
      if (ix == 0)      chk("R3 entry 0 unchanged", rd_data_a, 32'h0);
      else if (!en)     chk("R4 disabled write", rd_data_a, mdl[ix]);
      else              chk("R5 written value visible", rd_data_a, dt);
      chk("R9 equal indices", rd_data_b, rd_data_a);
      wr_en = 1'b0;
    end

    // R2: index 0 on both ports after writes to it
    @(posedge clk); #1;
    rd_idx_a = 5'd0; rd_idx_b = 5'd0; #1;
    chk("R2 port A zero", rd_data_a, 32'h0);
    chk("R2 port B zero", rd_data_b, 32'h0);

    // R8: independent ports
    rd_idx_a = 5'd31; rd_idx_b = 5'd16; #1;
    chk("R8 port A", rd_data_a, mdl[31]);
    chk("R8 port B", rd_data_b, mdl[16]);

    // R7: combinational follow without a clock edge
    @(posedge clk); #2;
    rd_idx_a = 5'd7; #1;
    chk("R7 index change A", rd_data_a, mdl[7]);
    rd_idx_b = 5'd1; #1;
    chk("R7 index change B", rd_data_b, mdl[1]);

    // R10: reset overrides a simultaneous write
    @(posedge clk); #1;
    rst = 1'b1; wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h55AA55AA;
    @(negedge clk); #1;
    rst = 1'b0; wr_en = 1'b0;
    rd_idx_a = 5'd9; rd_idx_b = 5'd7; #1;
    chk("R10 written entry cleared", rd_data_a, 32'h0);
    chk("R10 other entry cleared", rd_data_b, 32'h0);

    // R5 again after reset, high index boundary
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = 5'd31; wr_data = 32'h00000001;
    @(negedge clk); #1;
    wr_en = 1'b0;
    rd_idx_a = 5'd31; #1;
    chk("R5 index 31 after reset", rd_data_a, 32'h00000001);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule